// File: doc/BRIEF.md
# Packed Uniform Vector Write Assembler

This block sits behind a register write port and turns a stream of 32-bit writes into four-component shader constant vectors. Each component is a 24-bit float. A setup register picks the input mode and the target index. In single-precision mode, four data words each carry one IEEE-754 single, which the block converts to the 24-bit format. In packed mode, three data words carry four raw 24-bit values, and some of those values straddle word boundaries. When enough words have arrived, the block stores the complete vector in a 96-entry register file at the target index and moves the index on to the next entry.

Software loads a run of constants by writing the setup register once and then streaming data words. It may use any of eight aliased data addresses. A read port lets the surrounding logic, or a bench, fetch any entry. An error flag records any attempt to store a vector past the end of the file. The flag stays set until it is cleared.

The 24-bit float has 1 sign bit, a 7-bit exponent with bias 63 and a 16-bit mantissa, in that order from the most significant bit.

Top module: `uvec_assembler`

## Requirements
- R1: A write to address 0x040 loads the setup register. Data bit 31 selects the mode: 1 is single-precision, where a vector takes 4 words, and 0 is packed, where a vector takes 3 words. Data bits [6:0] set the target index. The write also discards any partly collected vector. The current mode and index are visible on `cur_f32` and `cur_idx`.
- R2: A write with `wr_en` high to any address from 0x048 to 0x04F feeds the next data word to the collector. Writes to other addresses, and cycles with `wr_en` low, do not advance the collection.
- R3: In single-precision mode, the first word received becomes component w, the second z, the third y and the fourth x.
- R4: Single-to-24-bit conversion keeps the sign and rebiases the exponent, so the new exponent is the old one minus 64. It keeps the top 16 mantissa bits. An input exponent of 64 or less gives a signed zero. An input exponent of 192 or more gives the sign with exponent 0x7F and mantissa 0xFFFF.
- R5: In packed mode, w is word0[31:8]. z is {word0[7:0], word1[31:16]}. y is {word1[15:0], word2[31:24]}. x is word2[23:0].
- R6: `vec_commit` pulses high for exactly one cycle, in the cycle after the final word of a vector is accepted. The stored vector is readable from the cycle after the pulse.
- R7: Each stored vector increments the index by one. Successive vectors therefore fill successive entries without any new setup write.
- R8: A vector that completes while the index is 96 or higher is discarded. In that case no pulse occurs, the index stays unchanged and `err_flag` is set.
- R9: `err_flag` stays set until `err_clr` is asserted. If a new error happens in the same cycle as the clear, the flag stays set.
- R10: A synchronous reset sets the index to 0, selects single-precision mode, discards any partial vector, clears the error flag and zeroes every entry.
- R11: `rd_vec` shows entry `rd_idx` combinationally, laid out as {w,z,y,x} with w in bits [95:72]. An `rd_idx` of 96 or higher reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_idx | input | 7 | Entry to read |
| rd_vec | output | 96 | Entry contents {w,z,y,x} |
| cur_idx | output | 7 | Current target index |
| cur_f32 | output | 1 | Current mode, 1 = single-precision |
| vec_commit | output | 1 | One-cycle store pulse |
| err_flag | output | 1 | Sticky out-of-range error |

## Verification
Some properties hold on every cycle, and the assertions watch these. The word counter never reaches a fourth slot in packed mode. A setup write always empties the counter. The store pulse never lasts two cycles and never aims outside the file. The error flag cannot drop without a clear. Other behaviour needs directed scenarios in the bench. These cover the component order and field unpacking, the conversion corner values, alias and non-alias addressing, a partial vector abandoned by a fresh setup, index advance across vectors, and the error priority over a clear.

// File: rtl/uvec_pkg.sv
package uvec_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned COMP_W = 24;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [COMP_W-1:0] f24_t;

   typedef struct packed {
      f24_t w;
      f24_t z;
      f24_t y;
      f24_t x;
   } uvec_t;
endpackage

// File: rtl/uvec_f24cvt.sv
module uvec_f24cvt
   import uvec_pkg::*;
(
   input  word_t sgl,
   output f24_t  res
);
   localparam int unsigned IN_BIAS  = 127;
   localparam int unsigned OUT_BIAS = 63;
   localparam logic [7:0]  SHIFT    = 8'(IN_BIAS - OUT_BIAS);
   localparam logic [7:0]  TOP_EXP  = 8'(SHIFT + 8'd127);

   logic       sgn;
   logic [7:0] e8;
   logic [7:0] e_new;

   assign sgn   = sgl[31];
   assign e8    = sgl[30:23];
   assign e_new = e8 - SHIFT;

   always_comb begin
      if (e8 <= SHIFT)
         res = {sgn, 23'd0};
      else if (e8 > TOP_EXP)
         res = {sgn, 7'h7F, 16'hFFFF};
      else
         res = {sgn, e_new[6:0], sgl[22:7]};
   end
endmodule

// File: rtl/uvec_pack.sv
module uvec_pack
   import uvec_pkg::*;
(
   input  logic [3:0][WORD_W-1:0] words,
   input  logic                   f32_mode,
   output uvec_t                  vec
);
   f24_t conv [4];
   uvec_t v_f32;
   uvec_t v_pk;

   for (genvar k = 0; k < 4; k++) begin : g_cvt
      uvec_f24cvt u_cvt (
         .sgl (words[k]),
         .res (conv[k])
      );
   end

   // arrival order lands on w first, x last
   assign v_f32 = '{w: conv[0], z: conv[1], y: conv[2], x: conv[3]};

   assign v_pk.w = words[0][31:8];
   assign v_pk.z = {words[0][7:0], words[1][31:16]};
   assign v_pk.y = {words[1][15:0], words[2][31:24]};
   assign v_pk.x = words[2][23:0];

   assign vec = f32_mode ? v_f32 : v_pk;
endmodule

// File: rtl/uvec_collect.sv
module uvec_collect
   import uvec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned IDX_W      = 7,
   parameter int unsigned DEPTH      = 96,
   parameter int unsigned NUM_ALIAS  = 8,
   parameter logic [ADDR_W-1:0] SETUP_ADDR = 10'h040,
   parameter logic [ADDR_W-1:0] DATA_BASE  = 10'h048
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  word_t                  wr_data,
   input  logic                   err_clr,
   output logic [3:0][WORD_W-1:0] words,
   output logic                   commit,
   output logic [IDX_W-1:0]       commit_idx,
   output logic                   commit_f32,
   output logic [IDX_W-1:0]       idx,
   output logic                   f32,
   output logic                   err
);
   localparam int unsigned AL_W = (NUM_ALIAS > 1) ? $clog2(NUM_ALIAS) : 1;
   localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

   if (DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("DEPTH does not fit in IDX_W");
   end
   if ((NUM_ALIAS & (NUM_ALIAS - 1)) != 0) begin : g_bad_alias
      $error("NUM_ALIAS must be a power of two");
   end

   logic data_hit;
   logic setup_hit;
   logic [1:0] cnt;
   logic last;

   if (NUM_ALIAS == 1) begin : g_one_alias
      assign data_hit = wr_en && (wr_addr == DATA_BASE);
   end else begin : g_multi_alias
      if (DATA_BASE[AL_W-1:0] != '0) begin : g_bad_base
         $error("DATA_BASE must be aligned to NUM_ALIAS");
      end
      if (SETUP_ADDR[ADDR_W-1:AL_W] == DATA_BASE[ADDR_W-1:AL_W]) begin : g_overlap
         $error("SETUP_ADDR lies inside the data alias window");
      end
      assign data_hit = wr_en && (wr_addr[ADDR_W-1:AL_W] == DATA_BASE[ADDR_W-1:AL_W]);
   end

   assign setup_hit = wr_en && (wr_addr == SETUP_ADDR);
   assign last      = f32 ? (cnt == 2'd3) : (cnt == 2'd2);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt        <= '0;
         idx        <= '0;
         f32        <= 1'b1;
         err        <= 1'b0;
         commit     <= 1'b0;
         commit_idx <= '0;
         commit_f32 <= 1'b1;
         words      <= '0;
      end else begin
         commit <= 1'b0;
         if (err_clr) err <= 1'b0;
         if (setup_hit) begin
            f32 <= wr_data[31];
            idx <= wr_data[IDX_W-1:0];
            cnt <= '0;
         end else if (data_hit) begin
            words[cnt] <= wr_data;
            if (last) begin
               cnt        <= '0;
               commit_f32 <= f32;
               if ({1'b0, idx} < DEPTH_V) begin
                  commit     <= 1'b1;
                  commit_idx <= idx;
                  idx        <= idx + 1'b1;
               end else begin
                  err <= 1'b1;
               end
            end else begin
               cnt <= cnt + 2'd1;
            end
         end
      end
   end

   p_packed_cnt_r5: assert property (@(posedge clk) disable iff (rst)
      !f32 |-> (cnt != 2'd3));
   p_setup_flush_r1: assert property (@(posedge clk) disable iff (rst)
      setup_hit |=> (cnt == 2'd0));
   p_commit_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      commit |=> !commit);
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (err && !err_clr) |=> err);
   p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
      commit |-> (idx == commit_idx + 1'b1));
endmodule

// File: rtl/uvec_file.sv
module uvec_file
   import uvec_pkg::*;
#(
   parameter int unsigned IDX_W = 7,
   parameter int unsigned DEPTH = 96
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  uvec_t            wdata,
   input  logic [IDX_W-1:0] ridx,
   output uvec_t            rdata
);
   localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

   uvec_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = ({1'b0, ridx} < DEPTH_V) ? mem[ridx] : '0;

   p_wr_in_range_r8: assert property (@(posedge clk) disable iff (rst)
      we |-> ({1'b0, widx} < DEPTH_V));
endmodule

// File: rtl/uvec_assembler.sv
module uvec_assembler
   import uvec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned DEPTH     = 96,
   parameter int unsigned NUM_ALIAS = 8,
   parameter logic [ADDR_W-1:0] SETUP_ADDR = 10'h040,
   parameter logic [ADDR_W-1:0] DATA_BASE  = 10'h048
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              err_clr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [95:0]       rd_vec,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              cur_f32,
   output logic              vec_commit,
   output logic              err_flag
);
   logic [3:0][WORD_W-1:0] words;
   logic [IDX_W-1:0]       commit_idx;
   logic                   commit_f32;
   uvec_t                  asm_vec;
   uvec_t                  rd_q;

   uvec_collect #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .NUM_ALIAS(NUM_ALIAS),
      .SETUP_ADDR(SETUP_ADDR), .DATA_BASE(DATA_BASE)
   ) u_collect (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .err_clr    (err_clr),
      .words      (words),
      .commit     (vec_commit),
      .commit_idx (commit_idx),
      .commit_f32 (commit_f32),
      .idx        (cur_idx),
      .f32        (cur_f32),
      .err        (err_flag)
   );

   uvec_pack u_pack (
      .words    (words),
      .f32_mode (commit_f32),
      .vec      (asm_vec)
   );

   uvec_file #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_file (
      .clk   (clk),
      .rst   (rst),
      .we    (vec_commit),
      .widx  (commit_idx),
      .wdata (asm_vec),
      .ridx  (rd_idx),
      .rdata (rd_q)
   );

   assign rd_vec = rd_q;
endmodule

// File: tb/sim_uvec_assembler.sv
`timescale 1ns/1ps
module sim_uvec_assembler;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [9:0]  wr_addr;
   logic [31:0] wr_data;
   logic        err_clr;
   logic [6:0]  rd_idx;
   logic [95:0] rd_vec;
   logic [6:0]  cur_idx;
   logic        cur_f32;
   logic        vec_commit;
   logic        err_flag;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   uvec_assembler u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .err_clr(err_clr), .rd_idx(rd_idx), .rd_vec(rd_vec), .cur_idx(cur_idx),
      .cur_f32(cur_f32), .vec_commit(vec_commit), .err_flag(err_flag)
   );

   typedef struct packed {
      logic         setup;
      logic         f32;
      logic [6:0]   idx;
      logic [127:0] words;
      logic [95:0]  exp;
   } row_t;

   localparam row_t TBL [5] = '{
      '{1'b1, 1'b1, 7'd0,  128'h3F800000_40000000_BFC00000_80000000, 96'h3F0000_400000_BF8000_800000},
      '{1'b1, 1'b1, 7'd5,  128'h20000000_20800000_5F800000_E0000000, 96'h000000_010000_7F0000_FFFFFF},
      '{1'b1, 1'b1, 7'd95, 128'h7F800000_3F812345_00000001_C0490FDB, 96'h7FFFFF_3F0246_000000_C0921F},
      '{1'b1, 1'b0, 7'd10, 128'h11223344_55667788_99AABBCC_00000000, 96'h112233_445566_778899_AABBCC},
      '{1'b0, 1'b0, 7'd11, 128'h00000001_FFFF0000_00FFFFFF_00000000, 96'h000000_01FFFF_000000_FFFFFF}
   };

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input logic [9:0] a, input logic [31:0] d);
      wr_en = 1'b0; wr_addr = a; wr_data = d;
      @(negedge clk);
   endtask

   task automatic setup(input logic f, input logic [6:0] i);
      wr(10'h040, {f, 24'd0, i});
   endtask

   task automatic rdv(input logic [6:0] i, output logic [95:0] v);
      rd_idx = i; #1; v = rd_vec;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [95:0] v;
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; err_clr = 1'b0; rd_idx = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10 reset state
      chk("R10 idx", 96'(cur_idx), 96'd0);
      chk("R10 mode", 96'(cur_f32), 96'd1);
      chk("R10 err", 96'(err_flag), 96'd0);
      chk("R10 commit", 96'(vec_commit), 96'd0);
      rdv(7'd0, v);  chk("R10 entry0", v, '0);
      rdv(7'd95, v); chk("R10 entry95", v, '0);

      // table walk: R3 R4 R5 R6 R7
      for (int r = 0; r < 5; r++) begin
         int n;
         n = TBL[r].f32 ? 4 : 3;
         if (TBL[r].setup) setup(TBL[r].f32, TBL[r].idx);
         for (int k = 0; k < n; k++)
            wr(10'(10'h048 + 10'((k + r) % 8)), TBL[r].words[127 - 32*k -: 32]);
         chk("R6 pulse high", 96'(vec_commit), 96'd1);
         @(negedge clk);
         chk("R6 pulse low", 96'(vec_commit), 96'd0);
         rdv(TBL[r].idx, v);
         chk(TBL[r].f32 ? "R3/R4 vector" : "R5 vector", v, TBL[r].exp);
         chk("R7 index advance", 96'(cur_idx), 96'(TBL[r].idx) + 96'd1);
      end

      // R8 out of range, R9 sticky
      setup(1'b1, 7'd96);
      for (int k = 0; k < 4; k++) wr(10'h048, 32'h3F800000);
      chk("R8 err set", 96'(err_flag), 96'd1);
      chk("R8 no pulse", 96'(vec_commit), 96'd0);
      chk("R8 index held", 96'(cur_idx), 96'd96);
      @(negedge clk);
      rdv(7'd95, v); chk("R8 entry95 intact", v, TBL[2].exp);
      setup(1'b1, 7'd127);
      for (int k = 0; k < 4; k++) wr(10'h04D, 32'h40000000);
      chk("R8 idx127 held", 96'(cur_idx), 96'd127);
      idle(10'h000, 32'h0);
      chk("R9 sticky", 96'(err_flag), 96'd1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      chk("R9 cleared", 96'(err_flag), 96'd0);
      setup(1'b0, 7'd96);
      wr(10'h048, 32'h1); wr(10'h049, 32'h2);
      err_clr = 1'b1; wr(10'h04A, 32'h3); err_clr = 1'b0;
      chk("R9 set wins over clear", 96'(err_flag), 96'd1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;

      // R1 partial vector dropped by setup
      setup(1'b0, 7'd30);
      chk("R1 mode packed", 96'(cur_f32), 96'd0);
      chk("R1 index loaded", 96'(cur_idx), 96'd30);
      wr(10'h048, 32'hAAAAAAAA); wr(10'h049, 32'hBBBBBBBB);
      setup(1'b0, 7'd30);
      wr(10'h04A, 32'h11223344); wr(10'h04B, 32'h55667788); wr(10'h04C, 32'h99AABBCC);
      @(negedge clk);
      rdv(7'd30, v); chk("R1 no merge", v, TBL[3].exp);
      rdv(7'd31, v); chk("R1 next entry untouched", v, '0);
      chk("R1 index", 96'(cur_idx), 96'd31);

      // R2 aliases and ignored writes
      setup(1'b1, 7'd40);
      wr(10'h048, 32'h3F800000);
      wr(10'h050, 32'hDEADBEEF);
      wr(10'h047, 32'hCAFEF00D);
      idle(10'h049, 32'h12345678);
      chk("R2 ignored no pulse", 96'(vec_commit), 96'd0);
      wr(10'h04F, 32'h40000000);
      wr(10'h04C, 32'hBFC00000);
      wr(10'h04A, 32'h80000000);
      @(negedge clk);
      rdv(7'd40, v); chk("R2 alias vector", v, TBL[0].exp);
      chk("R2 index", 96'(cur_idx), 96'd41);

      // R11 out-of-range read
      rdv(7'd100, v); chk("R11 high read zero", v, '0);

      // R10 reset again
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      rdv(7'd0, v); chk("R10 entry cleared", v, '0);
      chk("R10 idx cleared", 96'(cur_idx), 96'd0);
      chk("R10 err cleared", 96'(err_flag), 96'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule